// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block decides, cycle by cycle, which instruction may move forward in a small core whose functional units run in parallel and can finish in any order. Each cycle a decoder offers at most one decoded instruction: a target unit, a destination register, two source registers and an opcode. The controller accepts it with an issue grant or refuses it. A refused instruction stays on the inputs, and everything behind it waits, so issue follows program order.

Once an instruction has issued, the controller tells its unit when the source operands may be read. The unit reports the end of execution with a one-cycle done pulse. The controller then tells the unit when it may write its destination register. All decisions come from two tables that the controller keeps internally. One holds a status entry per functional unit. The other records, for each architectural register, which unit will write it next. The controller carries no operand data.

Read-after-write hazards are resolved at operand read. Write-after-read hazards are resolved by holding back the write. Write-after-write hazards and busy units are resolved by stalling issue. There is no renaming: every dependency is tracked by architectural register name.

Top module: `issue_scoreboard`

## Requirements
- R1: After reset every unit is free and no register is pending. `readGrant` and `writeGrant` are all zero, and a valid instruction is granted issue in the first cycle after reset.
- R2: An instruction is refused issue while its target unit is busy. A unit is busy from the cycle after its issue until the cycle after its write grant.
- R3: An instruction is refused issue while any busy unit holds its destination register as its destination.
- R4: At most one instruction issues per cycle. `issueGrant` is 0 whenever `instValid` is 0.
- R5: A unit is granted operand read only when neither source register has a pending producer. If a source is pending at issue, the read grant comes no earlier than the cycle after that producer's write grant.
- R6: Each issued instruction receives exactly one `readGrant` pulse of one cycle.
- R7: A done pulse from a unit that has not yet read its operands is ignored. After a done pulse that follows the read, the unit becomes eligible to write in the next cycle.
- R8: A unit's write is withheld while another busy unit has that register as a source that is ready but not yet read. The write is granted in the cycle after that read.
- R9: At most one write is granted per cycle. Among eligible units, the lowest unit index wins; bit i of `writeGrant` is unit i.
- R10: A write grant frees the unit and clears the register's pending state. From the next cycle, an instruction targeting that unit or that destination register can issue.
- R11: An instruction that issues in the same cycle as the write grant of its source's producer treats that source as ready. It is granted operand read in the next cycle if the other source is also ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | A decoded instruction is offered |
| instFu | input | 2 | Target functional unit index |
| instOp | input | 4 | Opcode, recorded in the unit's status entry |
| instDst | input | 4 | Destination register |
| instSrc1 | input | 4 | First source register |
| instSrc2 | input | 4 | Second source register |
| execDone | input | 4 | Per-unit one-cycle pulse marking the end of execution |
| issueGrant | output | 1 | The offered instruction is accepted in this cycle |
| readGrant | output | 4 | Per-unit permission to read source operands |
| writeGrant | output | 4 | Per-unit permission to write the result (at most one bit set) |

## Verification
Every grant is combinational from the tables, so a wrong table bit shows up at the ports in the cycle after the bad update.

- A lost pending bit shows up as a premature `readGrant` or a missing issue stall.
- A stuck busy flag or a stale producer tag shows up as an issue stall or a read grant that never arrives. The bench detects this at the first cycle where the expected grant is missing.
- A missed write-after-read check shows up as a `writeGrant` one or more cycles too early, while the reader's `readGrant` is still pending.

The bench compares each grant vector against the cycle derived from the rules above.

// File: rtl/sb_pkg.sv
package sb_pkg;
  parameter int NUM_FU  = 4;
  parameter int NUM_REG = 16;
  parameter int OP_W    = 4;
  localparam int FU_W   = $clog2(NUM_FU);
  localparam int REG_W  = $clog2(NUM_REG);

  typedef logic [FU_W-1:0]  fuIdx_t;
  typedef logic [REG_W-1:0] regIdx_t;

  // per-unit status entry
  typedef struct packed {
    logic            busy;
    logic [OP_W-1:0] op;
    regIdx_t         fi;
    regIdx_t         fj;
    regIdx_t         fk;
    fuIdx_t          qj;
    fuIdx_t          qk;
    logic            rj;
    logic            rk;
    logic            opsRead;
    logic            execFin;
  } fuEntry_t;

  // per-register result status
  typedef struct packed {
    logic   pending;
    fuIdx_t owner;
  } regStat_t;

  // strobes from control to the table datapath
  typedef struct packed {
    logic              issue;
    fuIdx_t            issueFu;
    logic [NUM_FU-1:0] readMask;
    logic [NUM_FU-1:0] finMask;
    logic              write;
    fuIdx_t            writeFu;
  } sbStrobe_t;
endpackage

// File: rtl/sb_table.sv
module sb_table
  import sb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  sbStrobe_t  strb,
  input  logic [OP_W-1:0] instOp,
  input  regIdx_t    instDst,
  input  regIdx_t    instSrc1,
  input  regIdx_t    instSrc2,
  output fuEntry_t   fuTab  [NUM_FU],
  output regStat_t   regTab [NUM_REG]
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int u = 0; u < NUM_FU; u++) fuTab[u] <= '0;
      for (int r = 0; r < NUM_REG; r++) regTab[r] <= '0;
    end else begin
      for (int u = 0; u < NUM_FU; u++) begin
        if (strb.write && strb.writeFu == fuIdx_t'(u)) begin
          fuTab[u] <= '0;
        end else begin
          if (strb.readMask[u]) begin
            fuTab[u].rj      <= 1'b0;
            fuTab[u].rk      <= 1'b0;
            fuTab[u].opsRead <= 1'b1;
          end
          if (strb.finMask[u]) fuTab[u].execFin <= 1'b1;
          // result broadcast to waiting consumers
          if (strb.write && fuTab[u].busy && !fuTab[u].opsRead) begin
            if (!fuTab[u].rj && fuTab[u].qj == strb.writeFu) fuTab[u].rj <= 1'b1;
            if (!fuTab[u].rk && fuTab[u].qk == strb.writeFu) fuTab[u].rk <= 1'b1;
          end
        end
        if (strb.issue && strb.issueFu == fuIdx_t'(u)) begin
          fuTab[u].busy    <= 1'b1;
          fuTab[u].op      <= instOp;
          fuTab[u].fi      <= instDst;
          fuTab[u].fj      <= instSrc1;
          fuTab[u].fk      <= instSrc2;
          fuTab[u].qj      <= regTab[instSrc1].owner;
          fuTab[u].qk      <= regTab[instSrc2].owner;
          // a producer writing in this very cycle counts as done
          fuTab[u].rj      <= !regTab[instSrc1].pending ||
                              (strb.write && regTab[instSrc1].owner == strb.writeFu);
          fuTab[u].rk      <= !regTab[instSrc2].pending ||
                              (strb.write && regTab[instSrc2].owner == strb.writeFu);
          fuTab[u].opsRead <= 1'b0;
          fuTab[u].execFin <= 1'b0;
        end
      end
      for (int r = 0; r < NUM_REG; r++) begin
        if (strb.write && fuTab[strb.writeFu].fi == regIdx_t'(r))
          regTab[r].pending <= 1'b0;
        if (strb.issue && instDst == regIdx_t'(r)) begin
          regTab[r].pending <= 1'b1;
          regTab[r].owner   <= strb.issueFu;
        end
      end
    end
  end

  assert_write_frees_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.write |=> !fuTab[$past(strb.writeFu)].busy);

  assert_dst_pending_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |=> regTab[$past(instDst)].pending);

endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  fuIdx_t            instFu,
  input  regIdx_t           instDst,
  input  logic [NUM_FU-1:0] execDone,
  input  fuEntry_t          fuTab  [NUM_FU],
  input  regStat_t          regTab [NUM_REG],
  output sbStrobe_t         strb,
  output logic              issueGrant,
  output logic [NUM_FU-1:0] readGrant,
  output logic [NUM_FU-1:0] writeGrant
);

  logic [NUM_FU-1:0] warBlock;
  logic [NUM_FU-1:0] writeElig;
  fuIdx_t            writeSel;

  always_comb begin
    issueGrant = instValid && !fuTab[instFu].busy && !regTab[instDst].pending;
    for (int u = 0; u < NUM_FU; u++) begin
      readGrant[u]     = fuTab[u].busy && !fuTab[u].opsRead && fuTab[u].rj && fuTab[u].rk;
      strb.finMask[u]  = execDone[u] && fuTab[u].busy && fuTab[u].opsRead && !fuTab[u].execFin;
      warBlock[u] = 1'b0;
      for (int v = 0; v < NUM_FU; v++) begin
        if (v != u && fuTab[v].busy &&
            ((fuTab[v].fj == fuTab[u].fi && fuTab[v].rj) ||
             (fuTab[v].fk == fuTab[u].fi && fuTab[v].rk)))
          warBlock[u] = 1'b1;
      end
      writeElig[u] = fuTab[u].busy && fuTab[u].execFin && !warBlock[u];
    end
    writeSel = '0;
    for (int u = NUM_FU - 1; u >= 0; u--)
      if (writeElig[u]) writeSel = fuIdx_t'(u);
    writeGrant = '0;
    if (|writeElig) writeGrant[writeSel] = 1'b1;
    strb.issue    = issueGrant;
    strb.issueFu  = instFu;
    strb.readMask = readGrant;
    strb.write    = |writeElig;
    strb.writeFu  = writeSel;
  end

  assert_issue_claims_R2: assert property (@(posedge clk) disable iff (!rstN)
    issueGrant |=> fuTab[$past(instFu)].busy);

  assert_single_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(writeGrant));

  for (genvar g = 0; g < NUM_FU; g++) begin : gReadOnce
    assert_read_once_R6: assert property (@(posedge clk) disable iff (!rstN)
      readGrant[g] |=> !readGrant[g]);
  end

endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import sb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    instValid,
  input  logic [FU_W-1:0]         instFu,
  input  logic [OP_W-1:0]         instOp,
  input  logic [REG_W-1:0]        instDst,
  input  logic [REG_W-1:0]        instSrc1,
  input  logic [REG_W-1:0]        instSrc2,
  input  logic [NUM_FU-1:0]       execDone,
  output logic                    issueGrant,
  output logic [NUM_FU-1:0]       readGrant,
  output logic [NUM_FU-1:0]       writeGrant
);

  sbStrobe_t strb;
  fuEntry_t  fuTab  [NUM_FU];
  regStat_t  regTab [NUM_REG];

  sb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instFu(instFu),
    .instDst(instDst), .execDone(execDone), .fuTab(fuTab), .regTab(regTab),
    .strb(strb), .issueGrant(issueGrant), .readGrant(readGrant),
    .writeGrant(writeGrant)
  );

  sb_table table_i (
    .clk(clk), .rstN(rstN), .strb(strb), .instOp(instOp), .instDst(instDst),
    .instSrc1(instSrc1), .instSrc2(instSrc2), .fuTab(fuTab), .regTab(regTab)
  );

endmodule

// File: tb/issue_scoreboard_tb.sv
module issue_scoreboard_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic       instValid;
  logic [1:0] instFu;
  logic [3:0] instOp;
  logic [3:0] instDst, instSrc1, instSrc2;
  logic [3:0] execDone;
  logic       issueGrant;
  logic [3:0] readGrant, writeGrant;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  issue_scoreboard dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instFu(instFu),
    .instOp(instOp), .instDst(instDst), .instSrc1(instSrc1), .instSrc2(instSrc2),
    .execDone(execDone), .issueGrant(issueGrant), .readGrant(readGrant),
    .writeGrant(writeGrant)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; instValid = 1'b0; instFu = '0; instOp = '0;
    instDst = '0; instSrc1 = '0; instSrc2 = '0; execDone = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // drive one cycle at the falling edge, then let combinational grants settle
  task automatic cyc(input logic v, input logic [1:0] fu, input logic [3:0] d,
                     input logic [3:0] s1, input logic [3:0] s2, input logic [3:0] done);
    @(negedge clk);
    instValid = v; instFu = fu; instDst = d; instSrc1 = s1; instSrc2 = s2;
    instOp = {2'b0, fu}; execDone = done;
    #1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R2 R3 R4 R5 R6: sweep of unit pairs, destination clash and source hit
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int sameDst = 0; sameDst < 2; sameDst++)
          for (int hit = 0; hit < 2; hit++) begin
            logic expIssue;
            doReset();
            cyc(1, 2'(a), 4'd1, 4'd8, 4'd9, 4'd0);
            check("R1 issue after reset", issueGrant, 1);
            check("R1 no grants after reset", {readGrant, writeGrant}, 0);
            expIssue = (a != b) && (sameDst == 0);
            cyc(1, 2'(b), sameDst ? 4'd1 : 4'd2, hit ? 4'd1 : 4'd10, 4'd11, 4'd0);
            check("R2/R3 issue decision", issueGrant, expIssue);
            check("R5 first unit reads", readGrant, 32'(1 << a));
            cyc(0, 2'(b), 4'd2, 4'd1, 4'd11, 4'd0);
            check("R4 no issue without valid", issueGrant, 0);
            if (expIssue)
              check("R5 RAW read gating", readGrant, hit ? 0 : 32'(1 << b));
            else
              check("R6 read once", readGrant, 0);
          end

    // divide then dependent add then independent sub on the busy add unit
    doReset();
    cyc(1, 2'd2, 4'd0, 4'd2, 4'd4, 4'd0);
    check("R1 div issues", issueGrant, 1);
    cyc(1, 2'd0, 4'd10, 4'd0, 4'd8, 4'd0);
    check("R3 add issues", issueGrant, 1);
    check("R5 div reads", readGrant, 4'b0100);
    cyc(1, 2'd0, 4'd12, 4'd8, 4'd14, 4'b0001);
    check("R2 sub stalls", issueGrant, 0);
    check("R5 add waits", readGrant, 0);
    cyc(1, 2'd0, 4'd12, 4'd8, 4'd14, 4'b0100);
    check("R7 early done ignored", writeGrant, 0);
    cyc(1, 2'd0, 4'd12, 4'd8, 4'd14, 4'b0000);
    check("R7 div writes", writeGrant, 4'b0100);
    check("R5 add still waits", readGrant, 0);
    cyc(1, 2'd0, 4'd12, 4'd8, 4'd14, 4'b0000);
    check("R5 add reads after write", readGrant, 4'b0001);
    check("R2 sub still stalls", issueGrant, 0);
    cyc(1, 2'd0, 4'd12, 4'd8, 4'd14, 4'b0001);
    check("R7 no write same cycle as done", writeGrant, 0);
    cyc(1, 2'd0, 4'd12, 4'd8, 4'd14, 4'b0000);
    check("R7 add writes", writeGrant, 4'b0001);
    check("R2 sub stalls at write", issueGrant, 0);
    cyc(1, 2'd0, 4'd12, 4'd8, 4'd14, 4'b0000);
    check("R10 sub issues after free", issueGrant, 1);

    // R8: write-after-read hold
    doReset();
    cyc(1, 2'd2, 4'd5, 4'd1, 4'd2, 4'd0);
    cyc(1, 2'd0, 4'd7, 4'd6, 4'd5, 4'd0);
    cyc(1, 2'd1, 4'd6, 4'd3, 4'd4, 4'd0);
    check("R3 writer of r6 issues", issueGrant, 1);
    check("R5 blocked reader", readGrant, 0);
    cyc(0, 2'd0, 4'd0, 4'd0, 4'd0, 4'd0);
    check("R5 writer reads", readGrant, 4'b0010);
    cyc(0, 2'd0, 4'd0, 4'd0, 4'd0, 4'b0010);
    cyc(0, 2'd0, 4'd0, 4'd0, 4'd0, 4'b0100);
    check("R8 write held", writeGrant, 0);
    cyc(0, 2'd0, 4'd0, 4'd0, 4'd0, 4'd0);
    check("R8 other unit writes", writeGrant, 4'b0100);
    cyc(0, 2'd0, 4'd0, 4'd0, 4'd0, 4'd0);
    check("R8 reader reads", readGrant, 4'b0001);
    check("R8 still held during read", writeGrant, 0);
    cyc(0, 2'd0, 4'd0, 4'd0, 4'd0, 4'd0);
    check("R8 write released", writeGrant, 4'b0010);

    // R9: simultaneous completion
    doReset();
    cyc(1, 2'd3, 4'd1, 4'd8, 4'd9, 4'd0);
    cyc(1, 2'd1, 4'd2, 4'd8, 4'd9, 4'd0);
    check("R6 unit3 reads", readGrant, 4'b1000);
    cyc(0, 2'd0, 4'd0, 4'd0, 4'd0, 4'd0);
    check("R6 unit1 reads", readGrant, 4'b0010);
    cyc(0, 2'd0, 4'd0, 4'd0, 4'd0, 4'b1010);
    cyc(0, 2'd0, 4'd0, 4'd0, 4'd0, 4'd0);
    check("R9 lowest index first", writeGrant, 4'b0010);
    cyc(0, 2'd0, 4'd0, 4'd0, 4'd0, 4'd0);
    check("R9 next writer", writeGrant, 4'b1000);

    // R11: issue in the producer's write cycle
    doReset();
    cyc(1, 2'd2, 4'd3, 4'd8, 4'd9, 4'd0);
    cyc(0, 2'd0, 4'd0, 4'd0, 4'd0, 4'd0);
    cyc(0, 2'd0, 4'd0, 4'd0, 4'd0, 4'b0100);
    cyc(1, 2'd0, 4'd4, 4'd3, 4'd3, 4'd0);
    check("R11 producer writes", writeGrant, 4'b0100);
    check("R11 consumer issues", issueGrant, 1);
    cyc(1, 2'd1, 4'd3, 4'd8, 4'd9, 4'd0);
    check("R11 consumer reads", readGrant, 4'b0001);
    check("R10 freed destination issues", issueGrant, 1);

    summary();
  end
endmodule